// File: doc/BRIEF.md
# Rotating Row Store for a Strided Convolution Window

This block keeps the most recent rows of one input channel on chip so that a K×K convolution engine with stride S can read a full window while the next S rows arrive. It holds K+S physical rows of WIDTH pixels. Pixels come in raster order on a valid/ready stream. The engine reads one column at a time. For that column the block returns K pixels, one for each logical row 0..K−1 of the current window.

No row is ever copied. A base pointer names the physical row that holds logical row 0. When a round advances, the base moves by S modulo K+S, and the rows that have just left the window become the next load region. The write side walks the physical rows in circular order.

A controller runs the rounds through six states:
- FILL: the first K rows load, and no window is offered.
- RUN: a window is offered while the next rows load.
- HOLD: the load is complete, and the writer is stalled until the engine finishes.
- STARVE: the engine has finished, the window is withdrawn, and the load continues.
- LAST: the final window is offered, and no more input is taken.
- DONE: end of frame.

Transitions:
- FILL→RUN, or FILL→LAST when HEIGHT equals K, on the last pixel of row K.
- RUN→HOLD on load completion.
- RUN→STARVE on engine done.
- RUN→RUN or RUN→LAST when load completion and engine done come in the same cycle.
- HOLD→RUN/LAST on engine done.
- STARVE→RUN/LAST on load completion.
- LAST→DONE on engine done.

Top module: `conv_line_rotator`

## Requirements
- R1: After reset, win_ready is 0, eof is 0 and in_ready is 1.
- R2: win_ready stays 0 until the K-th row's last pixel is accepted, and it is 1 in the cycle after that pixel is accepted.
- R3: While win_ready is 1 in round j (j starts at 0), lane r of win_data, at bits [r*PIX_W +: PIX_W], equals frame row j*S+r at column rd_col, for every r in 0..K−1.
- R4: While a window is offered, the writer is accepted for exactly S rows. After that, in_ready is 0 until the round advances, and pixels presented then change no stored data.
- R5: A win_done that arrives before the S rows are complete withdraws the window (win_ready 0) and keeps in_ready 1. The round advances in the cycle after the last pixel of the load.
- R6: A win_done in the same cycle as the last pixel of the load advances the round at once.
- R7: win_done has no effect while win_ready is 0.
- R8: Once all HEIGHT rows are accepted, in_ready stays 0. The final window is still served. After its win_done, eof is 1 and stays 1, and win_ready is 0.
- R9: The window base rotates by S modulo K+S each round, so windows whose rows wrap past the last physical row read correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts the input pixel |
| in_data | input | PIX_W | Input pixel, raster order |
| rd_col | input | clog2(WIDTH) | Column read by the engine |
| win_data | output | KSIZE*PIX_W | K pixels of the column, logical row r in lane r |
| win_ready | output | 1 | A complete window may be read |
| win_done | input | 1 | Engine finished the current window |
| eof | output | 1 | Frame finished, all windows served |

## Verification
If the base pointer is wrong, the window shows pixels of the wrong frame rows. This shows at once on the first read after an advance, and most clearly in the rounds whose rows wrap past the last physical row.

If the write pointer or row counter is wrong, stored pixels land in rows still in use. This shows as corrupted lanes in the same round or the next one.

A wrong state shows in the same cycle as a ready flag out of place: in_ready high while the writer should be held, or win_ready high before the rows exist. The checker ties each offered window to the number of pixels accepted so far.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
    typedef enum logic [2:0] {
        ST_FILL,
        ST_RUN,
        ST_HOLD,
        ST_STARVE,
        ST_LAST,
        ST_DONE
    } lbr_state_e;
endpackage

// File: rtl/lbr_fsm.sv
module lbr_fsm
    import lbr_pkg::*;
#(
    parameter int KSIZE  = 3,
    parameter int STRIDE = 1,
    parameter int WIDTH  = 8,
    parameter int HEIGHT = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic                                win_done,
    output logic                                in_ready,
    output logic                                win_ready,
    output logic                                eof,
    output logic                                wr_en,
    output logic [$clog2(KSIZE+STRIDE)-1:0]     wr_row,
    output logic [$clog2(WIDTH)-1:0]            wr_col,
    output logic [$clog2(KSIZE+STRIDE)-1:0]     base
);
    localparam int NROWS = KSIZE + STRIDE;
    localparam int PW    = $clog2(NROWS);
    localparam int CW    = $clog2(WIDTH);
    localparam int RW    = $clog2(HEIGHT + 1);
    localparam int GW    = $clog2(STRIDE + 1);

    lbr_state_e        st_q, st_d;
    logic [CW-1:0]     col_q;
    logic [RW-1:0]     rows_q;
    logic [PW-1:0]     phys_q, base_q, base_nx;
    logic [GW-1:0]     grp_q;
    logic [PW:0]       bsum;
    logic              accept, row_end, loading, load_done, advance;
    logic              last_in, after_row;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_FILL;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        loading   = (st_q == ST_RUN) || (st_q == ST_STARVE);
        in_ready  = (st_q == ST_FILL) || (loading && (rows_q < RW'(HEIGHT)));
        win_ready = (st_q == ST_RUN) || (st_q == ST_HOLD) || (st_q == ST_LAST);
        eof       = (st_q == ST_DONE);
        wr_row    = phys_q;
        wr_col    = col_q;
        base      = base_q;
    end

    always_comb begin
        accept    = in_valid && in_ready;
        wr_en     = accept;
        row_end   = accept && (col_q == CW'(WIDTH - 1));
        load_done = row_end && loading && (grp_q == GW'(STRIDE - 1));
        last_in   = (rows_q == RW'(HEIGHT));
        after_row = (rows_q == RW'(HEIGHT - 1));
        bsum      = {1'b0, base_q} + (PW+1)'(STRIDE);
        base_nx   = (bsum >= (PW+1)'(NROWS)) ? PW'(bsum - (PW+1)'(NROWS)) : PW'(bsum);
    end

    // next state
    always_comb begin
        st_d    = st_q;
        advance = 1'b0;
        unique case (st_q)
            ST_FILL: begin
                if (row_end && (rows_q == RW'(KSIZE - 1)))
                    st_d = (KSIZE == HEIGHT) ? ST_LAST : ST_RUN;
            end
            ST_RUN: begin
                if (load_done && win_done) begin
                    advance = 1'b1;
                    st_d    = after_row ? ST_LAST : ST_RUN;
                end else if (load_done) begin
                    st_d = ST_HOLD;
                end else if (win_done) begin
                    st_d = ST_STARVE;
                end
            end
            ST_HOLD: begin
                if (win_done) begin
                    advance = 1'b1;
                    st_d    = last_in ? ST_LAST : ST_RUN;
                end
            end
            ST_STARVE: begin
                if (load_done) begin
                    advance = 1'b1;
                    st_d    = after_row ? ST_LAST : ST_RUN;
                end
            end
            ST_LAST: begin
                if (win_done) st_d = ST_DONE;
            end
            ST_DONE: st_d = ST_DONE;
            default: st_d = ST_FILL;
        endcase
    end

    // counters and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q  <= '0;
            rows_q <= '0;
            phys_q <= '0;
            base_q <= '0;
            grp_q  <= '0;
        end else begin
            if (accept)
                col_q <= (col_q == CW'(WIDTH - 1)) ? '0 : col_q + 1'b1;
            if (row_end) begin
                rows_q <= rows_q + 1'b1;
                phys_q <= (phys_q == PW'(NROWS - 1)) ? '0 : phys_q + 1'b1;
            end
            if (advance) begin
                grp_q  <= '0;
                base_q <= base_nx;
            end else if (row_end && loading) begin
                grp_q <= grp_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lbr_rowmap.sv
module lbr_rowmap #(
    parameter int KSIZE  = 3,
    parameter int STRIDE = 1
) (
    input  logic [$clog2(KSIZE+STRIDE)-1:0]       base,
    output logic [KSIZE*$clog2(KSIZE+STRIDE)-1:0] phys_rows
);
    localparam int NROWS = KSIZE + STRIDE;
    localparam int PW    = $clog2(NROWS);

    for (genvar r = 0; r < KSIZE; r++) begin : g_map
        logic [PW:0] sum;
        always_comb begin
            sum = {1'b0, base} + (PW+1)'(r);
            phys_rows[r*PW +: PW] = (sum >= (PW+1)'(NROWS)) ?
                                    PW'(sum - (PW+1)'(NROWS)) : PW'(sum);
        end
    end
endmodule

// File: rtl/lbr_store.sv
module lbr_store #(
    parameter int KSIZE  = 3,
    parameter int STRIDE = 1,
    parameter int WIDTH  = 8,
    parameter int PIX_W  = 8
) (
    input  logic                                  clk,
    input  logic                                  wr_en,
    input  logic [$clog2(KSIZE+STRIDE)-1:0]       wr_row,
    input  logic [$clog2(WIDTH)-1:0]              wr_col,
    input  logic [PIX_W-1:0]                      wr_data,
    input  logic [$clog2(WIDTH)-1:0]              rd_col,
    input  logic [KSIZE*$clog2(KSIZE+STRIDE)-1:0] rd_rows,
    output logic [KSIZE*PIX_W-1:0]                rd_data
);
    localparam int NROWS = KSIZE + STRIDE;
    localparam int PW    = $clog2(NROWS);

    logic [PIX_W-1:0] mem [NROWS][WIDTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_row][wr_col] <= wr_data;
    end

    for (genvar r = 0; r < KSIZE; r++) begin : g_lane
        assign rd_data[r*PIX_W +: PIX_W] = mem[rd_rows[r*PW +: PW]][rd_col];
    end
endmodule

// File: rtl/conv_line_rotator.sv
module conv_line_rotator #(
    parameter int KSIZE  = 3,
    parameter int STRIDE = 1,
    parameter int WIDTH  = 8,
    parameter int HEIGHT = 6,
    parameter int PIX_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [PIX_W-1:0]           in_data,
    input  logic [$clog2(WIDTH)-1:0]   rd_col,
    output logic [KSIZE*PIX_W-1:0]     win_data,
    output logic                       win_ready,
    input  logic                       win_done,
    output logic                       eof
);
    localparam int PW = $clog2(KSIZE + STRIDE);
    localparam int CW = $clog2(WIDTH);

    logic            wr_en;
    logic [PW-1:0]   wr_row, base;
    logic [CW-1:0]   wr_col;
    logic [KSIZE*PW-1:0] phys_rows;

    lbr_fsm #(
        .KSIZE(KSIZE), .STRIDE(STRIDE), .WIDTH(WIDTH), .HEIGHT(HEIGHT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .win_done(win_done),
        .in_ready(in_ready), .win_ready(win_ready), .eof(eof),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .base(base)
    );

    lbr_rowmap #(.KSIZE(KSIZE), .STRIDE(STRIDE)) u_map (
        .base(base), .phys_rows(phys_rows)
    );

    lbr_store #(
        .KSIZE(KSIZE), .STRIDE(STRIDE), .WIDTH(WIDTH), .PIX_W(PIX_W)
    ) u_store (
        .clk(clk), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
        .wr_data(in_data), .rd_col(rd_col), .rd_rows(phys_rows),
        .rd_data(win_data)
    );
endmodule

// File: rtl/lbr_checker.sv
module lbr_checker #(
    parameter int KSIZE  = 3,
    parameter int STRIDE = 1,
    parameter int WIDTH  = 8,
    parameter int HEIGHT = 6
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic win_ready,
    input logic win_done,
    input logic eof
);
    int acc;
    int adv;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= 0;
            adv <= 0;
        end else begin
            if (in_valid && in_ready) acc <= acc + 1;
            if (win_done && win_ready) adv <= adv + 1;
        end
    end

    AST_WIN_AFTER_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        win_ready |-> (acc >= (KSIZE + adv*STRIDE)*WIDTH)); // R2
    AST_LOAD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (acc < (KSIZE + (adv+1)*STRIDE)*WIDTH)); // R4
    AST_NO_INPUT_PAST_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (acc >= HEIGHT*WIDTH) |-> !in_ready); // R8
    AST_EOF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> eof); // R8
    AST_EOF_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        eof |-> (!win_ready && !in_ready)); // R8
endmodule

bind conv_line_rotator lbr_checker #(
    .KSIZE(KSIZE), .STRIDE(STRIDE), .WIDTH(WIDTH), .HEIGHT(HEIGHT)
) u_lbr_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .win_ready(win_ready), .win_done(win_done), .eof(eof)
);

// File: tb/test_conv_line_rotator.sv
`timescale 1ns/1ps
module test_conv_line_rotator;
    localparam int K  = 3;
    localparam int S  = 1;
    localparam int W  = 8;
    localparam int H  = 6;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [PW-1:0] in_data = '0;
    logic [$clog2(W)-1:0] rd_col = '0;
    logic [K*PW-1:0] win_data;
    logic win_ready;
    logic win_done = 1'b0;
    logic eof;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    conv_line_rotator #(.KSIZE(K), .STRIDE(S), .WIDTH(W), .HEIGHT(H), .PIX_W(PW)) i_conv_line_rotator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .rd_col(rd_col), .win_data(win_data),
        .win_ready(win_ready), .win_done(win_done), .eof(eof)
    );

    function automatic logic [PW-1:0] pix(int r, int c);
        return PW'(r*16 + c + 1);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(logic v, logic [PW-1:0] d, logic dn);
        @(negedge clk);
        in_valid = v; in_data = d; win_done = dn;
        @(posedge clk);
        #1;
        in_valid = 1'b0; win_done = 1'b0;
    endtask

    task automatic put_row(int r, int ncols);
        for (int c = 0; c < ncols; c++) cyc(1'b1, pix(r, c), 1'b0);
    endtask

    task automatic check_window(int round, string req);
        for (int c = 0; c < W; c++) begin
            @(negedge clk);
            rd_col = c[$clog2(W)-1:0];
            #1;
            for (int r = 0; r < K; r++)
                check(req, int'(win_data[r*PW +: PW]), int'(pix(round*S + r, c)));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 win_ready", int'(win_ready), 0);
        check("R1 eof", int'(eof), 0);
        check("R1 in_ready", int'(in_ready), 1);
    endtask

    task automatic t_fill();
        put_row(0, W);
        put_row(1, W);
        put_row(2, W-1);
        @(negedge clk);
        check("R2 early win_ready", int'(win_ready), 0);
        cyc(1'b1, pix(2, W-1), 1'b0);
        @(negedge clk);
        check("R2 win_ready after fill", int'(win_ready), 1);
        check("R4 in_ready during window", int'(in_ready), 1);
    endtask

    task automatic t_starve();
        check_window(0, "R3 round0");
        cyc(1'b0, '0, 1'b1);
        @(negedge clk);
        check("R5 window withdrawn", int'(win_ready), 0);
        check("R5 writer open", int'(in_ready), 1);
        cyc(1'b0, '0, 1'b1);   // R7: ignored done
        put_row(3, W);
        @(negedge clk);
        check("R5 advance after load", int'(win_ready), 1);
        check_window(1, "R7 round1 not skipped");
    endtask

    task automatic t_hold();
        put_row(4, W);
        @(negedge clk);
        check("R4 writer stalled", int'(in_ready), 0);
        check("R4 window kept", int'(win_ready), 1);
        cyc(1'b1, 8'hEE, 1'b0);
        cyc(1'b1, 8'hEE, 1'b0);
        check_window(1, "R4 stalled write ignored");
        cyc(1'b0, '0, 1'b1);
        @(negedge clk);
        check("R4 writer reopened", int'(in_ready), 1);
        check_window(2, "R9 round2 wrap");
    endtask

    task automatic t_simul();
        put_row(5, W-1);
        cyc(1'b1, pix(5, W-1), 1'b1);
        @(negedge clk);
        check("R6 window after joint advance", int'(win_ready), 1);
        check("R8 input closed", int'(in_ready), 0);
        check_window(3, "R6 R9 round3");
    endtask

    task automatic t_drain();
        cyc(1'b1, 8'hEE, 1'b0);
        cyc(1'b1, 8'hEE, 1'b0);
        check_window(3, "R8 final window kept");
        check("R8 eof not yet", int'(eof), 0);
        cyc(1'b0, '0, 1'b1);
        @(negedge clk);
        check("R8 eof", int'(eof), 1);
        check("R8 no window", int'(win_ready), 0);
        check("R8 no input", int'(in_ready), 0);
        cyc(1'b0, '0, 1'b1);
        @(negedge clk);
        check("R8 eof sticky", int'(eof), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fill();
        t_starve();
        t_hold();
        t_simul();
        t_drain();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule